// File: doc/BRIEF.md
# Start-Gated Multi-Threshold Stop Conditioner

This block sits between six comparator outputs and a time-interval counter in a pulsed range finder. One comparator reports the outgoing laser pulse (the start). Five others report the return pulse (the stops), each set to a different detection threshold. A rising edge on the start line begins a shot. It re-arms all five stop channels and opens a blanking window whose length is a fixed base plus a value taken from a control input. While the window is open, light scattered inside the optics could trip the sensitive channels, so stop channels 1 to 4 are suppressed. Channel 0 has the highest threshold. It is never blanked, so very short ranges can still be measured.

The start edge reaches the timing stage through a fixed delay of a few clock cycles. This delay matches the start path to the stop path. Each stop channel passes only its first accepted rising edge per shot, as a one-cycle pulse. The block keeps a per-shot status: a mask of the channels that have fired, and for each channel its arrival rank. The sensitive channels cross their thresholds first, so the ranks let downstream logic estimate how bright the return was.

All inputs are treated as levels already synchronous to `clk`, and edges are found by comparing each level with its value in the previous cycle.

Top module: `stop_conditioner`

## Requirements
- R1: After reset every output is 0 and no stop channel is armed, so stop edges seen before the first start edge produce no `stopOut` pulse and leave `firedMask` at 0.
- R2: Stop channels 1 to 4 are suppressed while blanking is in effect. A rising edge on one of these channels is discarded if it occurs in the start-edge cycle or in any of the L cycles after it, where L = BASE_DLY + `blankExt`. The first edge that can pass is in cycle L+1 after the start edge.
- R3: Channel 0 is never blanked. An armed channel 0 edge produces a `stopOut[0]` pulse on the next clock, even while `blankOpen` is high.
- R4: `blankExt` is sampled on the start edge. `blankOpen` is 1 for exactly L cycles, beginning the cycle after the start edge.
- R5: `startOut` pulses high for one cycle, START_DLY clock cycles after the cycle in which the start rising edge is sampled (default 2).
- R6: Each channel passes only its first accepted rising edge per shot. A later start edge re-arms all channels, and also opens a new window while one is still open.
- R7: `firedMask[i]` is set in the same cycle that `stopOut[i]` pulses. It stays set until the next start edge clears it.
- R8: `rankOut[3i+2:3i]` gives channel i's arrival rank: the number of channels that fired in earlier cycles of the same shot. Channels that fire in the same cycle share a rank. A new start clears all ranks to 0.
- R9: Only rising edges count. A stop level that rises during blanking and stays high does not pass after the window closes. A stop edge in the same cycle as a start edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start comparator level |
| stopIn | input | 5 | Stop comparator levels; bit 0 is the high-threshold, never-blanked channel |
| blankExt | input | 8 | Blanking extension, in cycles, added to BASE_DLY |
| startOut | output | 1 | Delayed one-cycle start pulse toward the timing stage |
| stopOut | output | 5 | One-cycle pulse per accepted first stop edge |
| blankOpen | output | 1 | High while the blanking window counts down |
| firedMask | output | 5 | Channels that have fired in the current shot |
| rankOut | output | 15 | Packed 3-bit arrival rank per channel |

## Verification
On every cycle, the assertions check the following: no stop pulse on channels 1 to 4 right after a blanked cycle, at most one pulse per channel per shot, that `firedMask` marks a pulse and clears only on a start, that the rank written for a pulse equals the number of channels that had fired before it, and that the window opens after a start. Other behaviours depend on stimulus and are shown only by the bench scenarios: the exact window length for a given extension, the latency of the start delay, rejection of a held level, and re-arming by a second start. For these, the bench compares the design cycle by cycle against its behavioural model.

// File: rtl/stopcond_pkg.sv
package stopcond_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shotStart;  // start edge this cycle: re-arm, clear status
    logic blankOn;    // gated channels suppressed this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/stopcond_ctrl.sv
module stopcond_ctrl
  import stopcond_pkg::*;
#(
  parameter int EXT_W     = 8,
  parameter int BASE_DLY  = 4,
  parameter int START_DLY = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [EXT_W-1:0] blankExt,
  output ctrlStrobe_t      strobes,
  output logic             startOut,
  output logic             blankOpen
);
  localparam int CNT_W = $clog2(BASE_DLY + (1 << EXT_W));

  logic             startQ;
  logic             startEdge;
  logic [CNT_W-1:0] blankCnt;
  logic             cntLive;

  assign startEdge = startIn & ~startQ;
  assign cntLive   = (blankCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ   <= 1'b0;
      blankCnt <= '0;
    end else begin
      startQ <= startIn;
      if (startEdge)
        blankCnt <= CNT_W'(BASE_DLY) + CNT_W'(blankExt);
      else if (cntLive)
        blankCnt <= blankCnt - 1'b1;
    end
  end

  assign strobes.shotStart = startEdge;
  assign strobes.blankOn   = startEdge | cntLive;
  assign blankOpen         = cntLive;

  generate
    if (START_DLY == 0) begin : g_noDelay
      assign startOut = startEdge;
    end else begin : g_delay
      logic [START_DLY-1:0] startPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) startPipe <= '0;
        else if (START_DLY == 1) startPipe <= startEdge;
        else startPipe <= {startPipe[START_DLY-2:0], startEdge};
      end
      assign startOut = startPipe[START_DLY-1];
    end
  endgenerate
endmodule

// File: rtl/stopcond_path.sv
module stopcond_path
  import stopcond_pkg::*;
#(
  parameter int NUM_STOPS = 5,
  parameter int UNGATED   = 0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_STOPS-1:0]           stopIn,
  input  ctrlStrobe_t                    strobes,
  output logic [NUM_STOPS-1:0]           stopOut,
  output logic [NUM_STOPS-1:0]           firedMask,
  output logic [NUM_STOPS*$clog2(NUM_STOPS+1)-1:0] rankOut
);
  localparam int RANK_W = $clog2(NUM_STOPS + 1);

  logic [NUM_STOPS-1:0] stopQ;
  logic [NUM_STOPS-1:0] stopEdge;
  logic [NUM_STOPS-1:0] passMask;
  logic [NUM_STOPS-1:0] armed;
  logic [NUM_STOPS-1:0] accept;
  logic [RANK_W-1:0]    firedCnt;
  logic [RANK_W-1:0]    acceptCnt;

  assign stopEdge = stopIn & ~stopQ;

  generate
    for (genvar i = 0; i < NUM_STOPS; i++) begin : g_gate
      if (i == UNGATED) begin : g_open
        assign passMask[i] = 1'b1;
      end else begin : g_blank
        assign passMask[i] = ~strobes.blankOn;
      end
    end
  endgenerate

  assign accept = stopEdge & armed & passMask & {NUM_STOPS{~strobes.shotStart}};

  always_comb begin
    acceptCnt = '0;
    for (int i = 0; i < NUM_STOPS; i++)
      acceptCnt = acceptCnt + RANK_W'(accept[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stopQ     <= '0;
      armed     <= '0;
      firedMask <= '0;
      firedCnt  <= '0;
      stopOut   <= '0;
    end else begin
      stopQ   <= stopIn;
      stopOut <= accept;
      if (strobes.shotStart) begin
        armed     <= '1;
        firedMask <= '0;
        firedCnt  <= '0;
      end else begin
        armed     <= armed & ~accept;
        firedMask <= firedMask | accept;
        firedCnt  <= firedCnt + acceptCnt;
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_STOPS; i++) begin : g_rank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          rankOut[i*RANK_W +: RANK_W] <= '0;
        else if (strobes.shotStart)
          rankOut[i*RANK_W +: RANK_W] <= '0;
        else if (accept[i])
          rankOut[i*RANK_W +: RANK_W] <= firedCnt;
      end
    end
  endgenerate
endmodule

// File: rtl/stop_conditioner.sv
module stop_conditioner
  import stopcond_pkg::*;
#(
  parameter int NUM_STOPS = 5,
  parameter int EXT_W     = 8,
  parameter int BASE_DLY  = 4,
  parameter int START_DLY = 2,
  localparam int RANK_W   = $clog2(NUM_STOPS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startIn,
  input  logic [NUM_STOPS-1:0]        stopIn,
  input  logic [EXT_W-1:0]            blankExt,
  output logic                        startOut,
  output logic [NUM_STOPS-1:0]        stopOut,
  output logic                        blankOpen,
  output logic [NUM_STOPS-1:0]        firedMask,
  output logic [NUM_STOPS*RANK_W-1:0] rankOut
);
  ctrlStrobe_t strobes;

  stopcond_ctrl #(
    .EXT_W(EXT_W), .BASE_DLY(BASE_DLY), .START_DLY(START_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .blankExt(blankExt),
    .strobes(strobes), .startOut(startOut), .blankOpen(blankOpen)
  );

  stopcond_path #(
    .NUM_STOPS(NUM_STOPS), .UNGATED(0)
  ) u_path (
    .clk(clk), .rstN(rstN), .stopIn(stopIn), .strobes(strobes),
    .stopOut(stopOut), .firedMask(firedMask), .rankOut(rankOut)
  );
endmodule

// File: rtl/stop_conditioner_chk.sv
module stop_conditioner_chk #(
  parameter int NUM_STOPS = 5,
  parameter int RANK_W    = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        startIn,
  input logic [NUM_STOPS-1:0]        stopOut,
  input logic                        blankOpen,
  input logic [NUM_STOPS-1:0]        firedMask,
  input logic [NUM_STOPS*RANK_W-1:0] rankOut
);
  logic prevStart;
  logic seenEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevStart <= 1'b0;
    else       prevStart <= startIn;
  end
  assign seenEdge = startIn & ~prevStart;

  // R4: a start edge opens the window on the next cycle
  a_r4_window_opens: assert property (@(posedge clk) disable iff (!rstN)
    $past(seenEdge) |-> blankOpen);

  // R7: fired bits only clear on a start edge
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !$past(seenEdge) |-> (($past(firedMask) & ~firedMask) == '0));

  generate
    for (genvar i = 0; i < NUM_STOPS; i++) begin : g_ch
      if (i != 0) begin : g_gated
        // R2: gated channels never pass right after a blanked cycle
        a_r2_blanked: assert property (@(posedge clk) disable iff (!rstN)
          stopOut[i] |-> !$past(blankOpen) && !$past(seenEdge));
      end
      // R6: one pulse per channel per shot
      a_r6_first_only: assert property (@(posedge clk) disable iff (!rstN)
        stopOut[i] |-> !$past(firedMask[i]));
      // R7: a pulse is recorded
      a_r7_marked: assert property (@(posedge clk) disable iff (!rstN)
        stopOut[i] |-> firedMask[i]);
      // R8: rank equals channels fired earlier
      a_r8_rank: assert property (@(posedge clk) disable iff (!rstN)
        stopOut[i] |-> (32'(rankOut[i*RANK_W +: RANK_W]) == $countones($past(firedMask))));
    end
  endgenerate
endmodule

bind stop_conditioner stop_conditioner_chk #(
  .NUM_STOPS(NUM_STOPS), .RANK_W(RANK_W)
) u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .stopOut(stopOut),
  .blankOpen(blankOpen), .firedMask(firedMask), .rankOut(rankOut)
);

// File: tb/sim_stop_conditioner.sv
`timescale 1ns/1ps
module sim_stop_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int BASE = 4;
  localparam int SDLY = 2;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [N-1:0] stopIn = '0;
  logic [7:0] blankExt = '0;
  logic startOut, blankOpen;
  logic [N-1:0] stopOut, firedMask;
  logic [N*RW-1:0] rankOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  stop_conditioner u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .stopIn(stopIn),
    .blankExt(blankExt), .startOut(startOut), .stopOut(stopOut),
    .blankOpen(blankOpen), .firedMask(firedMask), .rankOut(rankOut)
  );

  int nChecks = 0;
  int nFails  = 0;
  int pulses[N];

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  mCnt;
  bit  mArmed[N];
  bit  mFired[N];
  int  mRank[N];
  int  mNum;
  bit  pStart;
  bit  pStop[N];
  bit  startQ[$];
  bit  eStop[N];
  bit  eStart;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mNum = 0; pStart = 0; eStart = 0;
      startQ.delete();
      for (int i = 0; i < N; i++) begin
        mArmed[i] = 0; mFired[i] = 0; mRank[i] = 0; pStop[i] = 0; eStop[i] = 0;
      end
    end else begin
      bit sr;
      bit blk;
      int added;
      sr = startIn && !pStart;
      for (int i = 0; i < N; i++) eStop[i] = 0;
      if (sr) begin
        for (int i = 0; i < N; i++) begin
          mArmed[i] = 1; mFired[i] = 0; mRank[i] = 0;
        end
        mNum = 0;
        mCnt = BASE + int'(blankExt);
      end else begin
        blk = (mCnt != 0);
        added = 0;
        for (int i = 0; i < N; i++) begin
          if (stopIn[i] && !pStop[i] && mArmed[i] && (i == 0 || !blk)) begin
            eStop[i] = 1; mArmed[i] = 0; mFired[i] = 1; mRank[i] = mNum;
            added++;
          end
        end
        mNum += added;
        if (mCnt > 0) mCnt--;
      end
      startQ.push_back(sr);
      if (startQ.size() > SDLY) void'(startQ.pop_front());
      eStart = (startQ.size() == SDLY) ? startQ[0] : 1'b0;
      pStart = startIn;
      for (int i = 0; i < N; i++) pStop[i] = stopIn[i];
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R5 startOut", int'(startOut), int'(eStart));
      check("R4 blankOpen", int'(blankOpen), int'(mCnt != 0));
      for (int i = 0; i < N; i++) begin
        check(i == 0 ? "R3 stopOut[0]" : "R2 stopOut", int'(stopOut[i]), int'(eStop[i]));
        check("R7 firedMask", int'(firedMask[i]), int'(mFired[i]));
        check("R8 rank", int'(rankOut[i*RW +: RW]), mRank[i]);
        if (stopOut[i]) pulses[i]++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStop(input logic [N-1:0] m);
    stopIn = stopIn | m; cyc(1); stopIn = stopIn & ~m;
  endtask

  task automatic doStart(input int ext);
    blankExt = 8'(ext); startIn = 1'b1; cyc(1); startIn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) pulses[i] = 0;
    cyc(3);
    #1;
    // R1: reset state
    check("R1 reset stopOut", int'(stopOut), 0);
    check("R1 reset firedMask", int'(firedMask), 0);
    check("R1 reset startOut", int'(startOut), 0);
    check("R1 reset blankOpen", int'(blankOpen), 0);
    @(negedge clk); rstN = 1'b1;
    cyc(2);
    // R1: unarmed stops ignored
    pulseStop(5'b11111); cyc(2); #1;
    check("R1 unarmed firedMask", int'(firedMask), 0);

    // shot A: L = 4, start held high a few cycles (R9 level)
    startIn = 1'b1; blankExt = 8'd0; cyc(1);
    pulseStop(5'b00011);          // ch1 blanked (R2), ch0 passes (R3)
    cyc(1); startIn = 1'b0;
    stopIn[2] = 1'b1;             // rises during blank, held (R9)
    cyc(6); #1;
    check("R3 ch0 during blank", int'(firedMask[0]), 1);
    check("R2 ch1 suppressed", int'(firedMask[1]), 0);
    check("R9 held level ignored", int'(firedMask[2]), 0);
    stopIn[2] = 1'b0;
    pulseStop(5'b10000); cyc(1);
    pulseStop(5'b01100); cyc(1);
    pulseStop(5'b00010);
    pulseStop(5'b10000);          // repeat edge ignored (R6)
    cyc(2); #1;
    check("R6 ch4 single pulse", pulses[4], 1);
    check("R8 ch2 rank", int'(rankOut[2*RW +: RW]), 2);
    check("R8 ch3 shared rank", int'(rankOut[3*RW +: RW]), 2);
    check("R8 ch1 rank", int'(rankOut[1*RW +: RW]), 4);

    // shot B: L = 14, stop coinciding with start is dropped (R9)
    blankExt = 8'd10; startIn = 1'b1; stopIn[0] = 1'b1; cyc(1);
    startIn = 1'b0; stopIn[0] = 1'b0; cyc(2); #1;
    check("R9 coincident stop dropped", int'(firedMask[0]), 0);
    check("R6 rearm clears mask", int'(firedMask), 0);
    cyc(10);
    pulseStop(5'b01000);          // still blanked (cycle 13 after start)
    cyc(1);
    pulseStop(5'b01000); cyc(2); #1;
    check("R2 extended window end", int'(firedMask[3]), 1);

    // shot C restarted while window open
    doStart(3); cyc(2);
    doStart(0); cyc(5);
    pulseStop(5'b11111); cyc(2); #1;
    check("R6 restart rearms all", int'(firedMask), 31);
    check("R8 all same rank", int'(rankOut), 0);
    cyc(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule